// File: doc/BRIEF.md
# Host IO Read Port for a Keyboard Character

This block connects an asynchronous 8-bit host bus to the internal clock domain of an FPGA. Through it the host can read a single character register over an IO read cycle. The same port address also accepts IO write cycles. For those the block only opens the bus transceiver, because the write data belongs to a separate path.

The block samples the host strobes and the low address byte through a two-flop synchroniser. It decodes IO reads and writes aimed at its port address. It then drives three things:

- the bidirectional data pins,
- the transceiver enable pin,
- the transceiver direction pin.

The data pins are driven only while a decoded read is in progress. At all other times they are left high-impedance.

An internal one-cycle strobe loads new characters into the register. The register is cleared to zero once the host has finished reading it. A host that polls the port therefore sees each key exactly once, and reads zero when nothing is waiting.

Top module: `io_char_port`

## Requirements
- R1: After reset, `xcvr_en_n` is 1, `xcvr_dir` is 0 (toward the FPGA), and the first read of the port returns 0x00.
- R2: A port read cycle has `iorq_n`=0, `rd_n`=0, `mreq_n`=1 and `addr`=0x01. During such a cycle the block sets `xcvr_dir`=1 and `xcvr_en_n`=0, and drives the character register's value onto `bus_data`.
- R3: A read of the port with no character waiting returns 0x00.
- R4: A read ends when its strobes return high. After that, the register is cleared, so the next read returns 0x00 unless a new character arrived in between.
- R5: An IO read at any address other than 0x01 leaves `xcvr_dir` at 0 and `xcvr_en_n` at 1, and does not disturb the stored character.
- R6: A cycle with `mreq_n`=0 is ignored. It leaves `xcvr_dir`=0 and `xcvr_en_n`=1, and the stored character is kept.
- R7: An IO write at 0x01 (`iorq_n`=0, `wr_n`=0) sets `xcvr_en_n`=0 with `xcvr_dir`=0. It does not drive `bus_data` and does not change the character.
- R8: Outside a port read, `bus_data` is high-impedance, so any value the host places on the pins is seen unchanged.
- R9: A pulse on `char_valid` loads `char_in` into the register and replaces any unread character.
- R10: A `char_valid` pulse may fall in the same clock as the clear at the end of a read. In that case the new character is kept.
- R11: The read data is captured when the read is decoded and stays stable until the read ends. A character that arrives during the read survives the end-of-read clear.
- R12: The response to a strobe change is not visible at the second clock edge after the change. It is visible at the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq_n | input | 1 | Host IO request, active low |
| mreq_n | input | 1 | Host memory request, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 8 | Low byte of the host address |
| bus_data | inout | 8 | Bidirectional host data pins |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 drives toward the host |
| char_in | input | 8 | New character from the keyboard side |
| char_valid | input | 1 | One-cycle strobe that loads `char_in` |

## Verification
Two functions can land in the same clock: the load from `char_valid` and the clear at the end of a host read. The bench lets a read end, counts the synchroniser and output register stages, and pulses `char_valid` in exactly the cycle whose edge performs the clear. The next read must then return the new character rather than 0x00. A second case places the pulse in the middle of a read. The data already on the pins must stay unchanged, and the late character must still be there on the following read.

// File: rtl/io_char_port.sv
module io_char_port #(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  PORT_ADDR   = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iorq_n,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] bus_data,
  output logic          xcvr_en_n,
  output logic          xcvr_dir,
  input  logic [DW-1:0] char_in,
  input  logic          char_valid
);
  localparam int SW = AW + 4;
  localparam logic [SW-1:0] SYNC_IDLE = {4'hF, {AW{1'b0}}};

  logic [SW-1:0] sync_q [SYNC_STAGES];
  logic [SW-1:0] s_bus;
  logic          s_iorq_n, s_mreq_n, s_rd_n, s_wr_n;
  logic [AW-1:0] s_addr;
  logic          hit, rd_sel, wr_sel, rd_sel_q, wr_sel_q;
  logic          rd_start, rd_end, fresh, clr;
  logic [DW-1:0] char_q, dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_IDLE;
    end else begin
      sync_q[0] <= {iorq_n, mreq_n, rd_n, wr_n, addr};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s_bus = sync_q[SYNC_STAGES-1];
  assign {s_iorq_n, s_mreq_n, s_rd_n, s_wr_n, s_addr} = s_bus;

  assign hit    = (s_addr == AW'(PORT_ADDR)) && !s_iorq_n && s_mreq_n;
  assign rd_sel = hit && !s_rd_n;
  assign wr_sel = hit && !s_wr_n && s_rd_n;

  assign rd_start = rd_sel && !rd_sel_q;
  assign rd_end   = rd_sel_q && !rd_sel;
  assign clr      = rd_end && !fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel_q <= 1'b0;
      wr_sel_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      rd_sel_q <= rd_sel;
      wr_sel_q <= wr_sel;
      if (rd_start) dout_q <= char_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      fresh  <= 1'b0;
    end else begin
      if (char_valid)      char_q <= char_in;
      else if (clr)        char_q <= '0;
      if (rd_start)        fresh <= char_valid;
      else if (char_valid) fresh <= 1'b1;
      else if (rd_end)     fresh <= 1'b0;
    end
  end

  assign xcvr_dir  = rd_sel_q;
  assign xcvr_en_n = !(rd_sel_q || wr_sel_q);
  assign bus_data  = rd_sel_q ? dout_q : {DW{1'bz}};
endmodule

module io_char_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xcvr_dir,
  input logic          xcvr_en_n,
  input logic [DW-1:0] dout_q,
  input logic [DW-1:0] char_q,
  input logic [DW-1:0] char_in,
  input logic          char_valid,
  input logic          fresh,
  input logic          s_iorq_n,
  input logic          s_mreq_n
);
  assert_dir_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_dir |-> !xcvr_en_n);

  assert_mem_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_dir) |-> ($past(s_mreq_n) && !$past(s_iorq_n)));

  assert_new_char_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> (char_q == $past(char_in)));

  assert_read_data_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_dir && $past(xcvr_dir)) |-> $stable(dout_q));

  assert_clear_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xcvr_dir) && !$past(char_valid) && !$past(fresh)) |-> (char_q == '0));
endmodule

bind io_char_port io_char_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xcvr_dir(xcvr_dir), .xcvr_en_n(xcvr_en_n),
  .dout_q(dout_q), .char_q(char_q), .char_in(char_in), .char_valid(char_valid),
  .fresh(fresh), .s_iorq_n(s_iorq_n), .s_mreq_n(s_mreq_n)
);

// File: tb/sim_io_char_port.sv
module sim_io_char_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       iorq_n = 1, mreq_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] addr = 0, char_in = 0, host_val = 8'hA5;
  logic       char_valid = 0, host_oe = 1;
  wire  [7:0] bus_data;
  logic       xcvr_en_n, xcvr_dir;
  int         n_run = 0, n_fail = 0;

  assign bus_data = host_oe ? host_val : 8'hzz;

  io_char_port u0 (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .bus_data(bus_data), .xcvr_en_n(xcvr_en_n),
    .xcvr_dir(xcvr_dir), .char_in(char_in), .char_valid(char_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] c);
    @(negedge clk); char_in = c; char_valid = 1;
    @(negedge clk); char_valid = 0;
  endtask

  task automatic io_read(input logic [7:0] a, input logic mem,
                         output logic [7:0] d, output logic dir, output logic en_n);
    @(negedge clk); addr = a; host_oe = 0;
    if (mem) mreq_n = 0; else iorq_n = 0;
    rd_n = 0;
    repeat (4) @(negedge clk);
    d = bus_data; dir = xcvr_dir; en_n = xcvr_en_n;
    iorq_n = 1; mreq_n = 1; rd_n = 1;
    repeat (4) @(negedge clk);
    host_oe = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic dir, en_n;
    repeat (3) @(negedge clk);
    check("R1 en_n", xcvr_en_n, 1);
    check("R1 dir", xcvr_dir, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 idle pins", bus_data, 8'hA5);
    io_read(8'h01, 0, d, dir, en_n);
    check("R1 first read", d, 0);
    check("R2 dir", dir, 1);
    check("R2 en", en_n, 0);

    // R9/R2/R4: sweep all character values through the register
    for (int c = 1; c < 256; c++) begin
      load(8'(c));
      io_read(8'h01, 0, d, dir, en_n);
      check("R2 read value", d, c);
      io_read(8'h01, 0, d, dir, en_n);
      check("R4 cleared", d, 0);
    end
    check("R3 empty read", d, 0);

    // R9: newer character replaces an unread one
    load(8'h11); load(8'h22);
    io_read(8'h01, 0, d, dir, en_n);
    check("R9 replace", d, 8'h22);

    // R5: every other address is ignored
    load(8'h3C);
    for (int a = 0; a < 256; a++) begin
      if (a == 1) continue;
      io_read(8'(a), 0, d, dir, en_n);
      check("R5 dir", dir, 0);
      check("R5 en", en_n, 1);
    end
    io_read(8'h01, 0, d, dir, en_n);
    check("R5 char kept", d, 8'h3C);

    // R6: memory cycle ignored
    load(8'h47);
    io_read(8'h01, 1, d, dir, en_n);
    check("R6 dir", dir, 0);
    check("R6 en", en_n, 1);
    io_read(8'h01, 0, d, dir, en_n);
    check("R6 char kept", d, 8'h47);

    // R7/R8: write at the port
    load(8'h58);
    @(negedge clk); host_val = 8'h5A; addr = 8'h01; iorq_n = 0; wr_n = 0;
    repeat (4) @(negedge clk);
    check("R7 en", xcvr_en_n, 0);
    check("R7 dir", xcvr_dir, 0);
    check("R8 write pins", bus_data, 8'h5A);
    iorq_n = 1; wr_n = 1;
    repeat (4) @(negedge clk);
    check("R7 en off", xcvr_en_n, 1);
    io_read(8'h01, 0, d, dir, en_n);
    check("R7 char kept", d, 8'h58);

    // R12: response at third edge, not second
    load(8'h6B);
    @(negedge clk); addr = 8'h01; host_oe = 0; iorq_n = 0; rd_n = 0;
    repeat (2) @(negedge clk);
    check("R12 not at 2", xcvr_dir, 0);
    @(negedge clk);
    check("R12 at 3", xcvr_dir, 1);
    check("R12 data", bus_data, 8'h6B);
    // R11: mid-read arrival
    char_in = 8'h7E; char_valid = 1;
    @(negedge clk); char_valid = 0;
    @(negedge clk);
    check("R11 stable", bus_data, 8'h6B);
    iorq_n = 1; rd_n = 1;
    repeat (4) @(negedge clk); host_oe = 1;
    io_read(8'h01, 0, d, dir, en_n);
    check("R11 survives", d, 8'h7E);

    // R10: new character on the clear edge
    load(8'h81);
    @(negedge clk); addr = 8'h01; host_oe = 0; iorq_n = 0; rd_n = 0;
    repeat (4) @(negedge clk);
    check("R10 first", bus_data, 8'h81);
    iorq_n = 1; rd_n = 1;
    repeat (2) @(negedge clk);
    char_in = 8'h92; char_valid = 1;
    @(negedge clk); char_valid = 0;
    repeat (2) @(negedge clk); host_oe = 1;
    io_read(8'h01, 0, d, dir, en_n);
    check("R10 new wins", d, 8'h92);
    io_read(8'h01, 0, d, dir, en_n);
    check("R4 after R10", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule